// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact load/store integer processor with five stages: fetch, decode with register read, execute or address calculation, memory access with branch completion, and write-back. Each stage passes its results to the next through a bank of inter-stage flops. The core connects to a synchronous instruction memory port and a synchronous data memory port. It executes register-register and register-immediate ALU operations, word loads and stores, and two branches that test one register against zero.

The core has no forwarding, no interlocks and no squashing. Software keeps two unrelated instructions (or NOPs) between an instruction that writes a register and any instruction that reads it. A taken branch changes the fetch stream only when the branch reaches the memory stage. The three words after a branch therefore always execute, and a program fills them with NOPs or with independent work. Both memories register their read data. The instruction memory is addressed with the next PC, so a word is available in the cycle its PC is current. A load's data comes back during write-back.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and during the first cycle after it is released, the core makes no data memory access and presents instruction address 0. Execution then starts at address 0, and every inter-stage register holds a NOP.
- R2: Apart from branch redirects, the instruction address presented each cycle is 4 above the previous one.
- R3: Instruction fields are laid out as follows. The opcode is word bits 31:26. The first source register is bits 25:21. Bits 20:16 hold the second source register, or the destination for immediate forms and loads. Bits 15:11 hold the register-register destination. Bits 10:3 must be zero in register-register form, and bits 2:0 give the function. The immediate is bits 15:0, sign-extended to 32 bits in every format.
- R4: Opcode 0x00 with function 0..7 computes add, subtract, and, or, xor, signed set-less-than, shift-left and logical shift-right. The shift amount is the second operand's bits 4:0, and the result goes to bits 15:11.
- R5: Opcodes 0x08..0x0F apply the function given by opcode bits 2:0 (same codes as R4) to the first source and the sign-extended immediate. The result goes to bits 20:16.
- R6: Opcode 0x23 loads the data word at first-source + immediate into bits 20:16. Opcode 0x2B writes the register named by bits 20:16 to that address. Read and write strobes are never active together.
- R7: Opcode 0x04 branches when the first source is zero, and 0x05 branches when it is non-zero. The target is the branch address + 4 + immediate. The three following words execute before the target is fetched.
- R8: Register 0 reads as zero, and writes to it are discarded.
- R9: A register value written back is visible to an instruction decoding in the same cycle, so two intervening words are enough between producer and consumer.
- R10: The all-zero word and any unlisted opcode or register-register function change no register and make no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 32 | Byte address of the word the instruction memory registers at the next edge |
| imem_rdata | input | 32 | Registered instruction word |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Registered load data, valid the cycle after the read strobe |

## Verification
Take an instruction word that arrives on the instruction port in cycle c. It decodes in c+1 and executes in c+2. Its memory strobe, address and store data appear in c+3, and a taken branch's target shows on the instruction address in that same cycle. Its register write lands at the end of c+4. The bench compares the instruction address with a behavioural reference stream at every falling edge after reset. It matches each data strobe against the next expected access in program order at the falling edge of the cycle in which the strobe is raised. Register effects are observed only through the stores that a closing sequence makes of every register, and are checked against both the reference memory image and hand-computed values.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;
  localparam int IMM_W  = 16;

  typedef enum logic [2:0] {
    K_NOP, K_ALU_R, K_ALU_I, K_LOAD, K_STORE, K_BEQZ, K_BNEZ
  } kind_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_OR = 3'd3,
    FN_XOR = 3'd4, FN_SLT = 3'd5, FN_SLL = 3'd6, FN_SRL = 3'd7
  } alu_fn_e;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_BNEZ = 6'h05;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;
  localparam logic [2:0] OPC_IMM_GROUP = 3'b001;

  typedef struct packed {
    kind_e               kind;
    alu_fn_e             fn;
    logic                wen;
    logic [RIDX_W-1:0]   dst;
  } ctl_t;

  localparam ctl_t CTL_NOP = '{kind: K_NOP, fn: FN_ADD, wen: 1'b0, dst: '0};
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0]   ir,
  output ctl_t              ctl,
  output logic [RIDX_W-1:0] src_a,
  output logic [RIDX_W-1:0] src_b,
  output logic [XLEN-1:0]   imm_ext
);
  logic [5:0]        opc;
  logic [RIDX_W-1:0] dst_rr;
  logic [7:0]        rr_pad;
  logic [2:0]        rr_fn;

  assign opc     = ir[31:26];
  assign src_a   = ir[25:21];
  assign src_b   = ir[20:16];
  assign dst_rr  = ir[15:11];
  assign rr_pad  = ir[10:3];
  assign rr_fn   = ir[2:0];
  assign imm_ext = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

  always_comb begin
    ctl = CTL_NOP;
    if (opc == OPC_RR) begin
      if (rr_pad == '0) begin
        ctl.kind = K_ALU_R;
        ctl.fn   = alu_fn_e'(rr_fn);
        ctl.dst  = dst_rr;
        ctl.wen  = (dst_rr != '0);
      end
    end else if (opc[5:3] == OPC_IMM_GROUP) begin
      ctl.kind = K_ALU_I;
      ctl.fn   = alu_fn_e'(opc[2:0]);
      ctl.dst  = src_b;
      ctl.wen  = (src_b != '0);
    end else if (opc == OPC_LW) begin
      ctl.kind = K_LOAD;
      ctl.dst  = src_b;
      ctl.wen  = (src_b != '0);
    end else if (opc == OPC_SW) begin
      ctl.kind = K_STORE;
    end else if (opc == OPC_BEQZ) begin
      ctl.kind = K_BEQZ;
    end else if (opc == OPC_BNEZ) begin
      ctl.kind = K_BNEZ;
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    unique case (fn)
      FN_ADD: y = a + b;
      FN_SUB: y = a - b;
      FN_AND: y = a & b;
      FN_OR:  y = a | b;
      FN_XOR: y = a ^ b;
      FN_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      FN_SLL: y = a << sh;
      FN_SRL: y = a >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];
  logic         wr_hit;

  assign wr_hit = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[wa] <= wd;
    end
  end

  always_comb begin
    if (ra_a == '0)                 rd_a = '0;
    else if (wr_hit && wa == ra_a)  rd_a = wd;
    else                            rd_a = regs[ra_a];
    if (ra_b == '0)                 rd_b = '0;
    else if (wr_hit && wa == ra_b)  rd_b = wd;
    else                            rd_b = regs[ra_b];
  end

  a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == '0) |-> (rd_a == '0));

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic        dmem_we,
  output logic        dmem_re,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

  // fetch
  logic [XLEN-1:0] pc_q, pc_d, pc_seq;
  logic            run_q, pc_en, br_take;
  // IF/ID
  logic [XLEN-1:0] ifid_ir_q, ifid_ir_d, ifid_npc_q, ifid_npc_d;
  // ID/EX
  ctl_t            idex_ctl_q, idex_ctl_d;
  logic [XLEN-1:0] idex_npc_q, idex_a_q, idex_a_d, idex_b_q, idex_b_d, idex_imm_q, idex_imm_d;
  logic [RIDX_W-1:0] id_src_a, id_src_b;
  // EX/MEM
  ctl_t            exmem_ctl_q;
  logic [XLEN-1:0] exmem_alu_q, exmem_alu_d, exmem_b_q, exmem_tgt_q, exmem_tgt_d;
  logic            exmem_cond_q, exmem_cond_d;
  logic [XLEN-1:0] ex_opb;
  // MEM/WB
  ctl_t            memwb_ctl_q;
  logic [XLEN-1:0] memwb_alu_q;
  // write-back
  logic            wb_we;
  logic [XLEN-1:0] wb_data;

  // ---------------- fetch, next-state ----------------
  always_comb begin
    br_take    = exmem_cond_q;
    pc_seq     = pc_q + WORD_BYTES;
    pc_d       = br_take ? exmem_tgt_q : pc_seq;
    pc_en      = run_q;
    imem_addr  = run_q ? pc_d : pc_q;
    ifid_ir_d  = run_q ? imem_rdata : '0;
    ifid_npc_d = pc_seq;
  end

  // ---------------- decode ----------------
  pipe5_decode u_dec (
    .ir      (ifid_ir_q),
    .ctl     (idex_ctl_d),
    .src_a   (id_src_a),
    .src_b   (id_src_b),
    .imm_ext (idex_imm_d)
  );

  pipe5_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_a  (id_src_a),
    .rd_a  (idex_a_d),
    .ra_b  (id_src_b),
    .rd_b  (idex_b_d),
    .we    (wb_we),
    .wa    (memwb_ctl_q.dst),
    .wd    (wb_data)
  );

  // ---------------- execute ----------------
  assign ex_opb = (idex_ctl_q.kind == K_ALU_R) ? idex_b_q : idex_imm_q;

  pipe5_alu #(.W(XLEN)) u_alu (
    .fn (idex_ctl_q.fn),
    .a  (idex_a_q),
    .b  (ex_opb),
    .y  (exmem_alu_d)
  );

  always_comb begin
    exmem_tgt_d  = idex_npc_q + idex_imm_q;
    exmem_cond_d = ((idex_ctl_q.kind == K_BEQZ) && (idex_a_q == '0)) ||
                   ((idex_ctl_q.kind == K_BNEZ) && (idex_a_q != '0));
  end

  // ---------------- memory ----------------
  always_comb begin
    dmem_addr  = exmem_alu_q;
    dmem_wdata = exmem_b_q;
    dmem_we    = (exmem_ctl_q.kind == K_STORE);
    dmem_re    = (exmem_ctl_q.kind == K_LOAD);
  end

  // ---------------- write-back ----------------
  always_comb begin
    wb_we   = memwb_ctl_q.wen;
    wb_data = (memwb_ctl_q.kind == K_LOAD) ? dmem_rdata : memwb_alu_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pc_q  <= RESET_PC;
    end else begin
      run_q <= 1'b1;
      if (pc_en) pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid_ir_q    <= '0;
      ifid_npc_q   <= '0;
      idex_ctl_q   <= CTL_NOP;
      idex_npc_q   <= '0;
      idex_a_q     <= '0;
      idex_b_q     <= '0;
      idex_imm_q   <= '0;
      exmem_ctl_q  <= CTL_NOP;
      exmem_alu_q  <= '0;
      exmem_b_q    <= '0;
      exmem_tgt_q  <= '0;
      exmem_cond_q <= 1'b0;
      memwb_ctl_q  <= CTL_NOP;
      memwb_alu_q  <= '0;
    end else begin
      ifid_ir_q    <= ifid_ir_d;
      ifid_npc_q   <= ifid_npc_d;
      idex_ctl_q   <= idex_ctl_d;
      idex_npc_q   <= ifid_npc_q;
      idex_a_q     <= idex_a_d;
      idex_b_q     <= idex_b_d;
      idex_imm_q   <= idex_imm_d;
      exmem_ctl_q  <= idex_ctl_q;
      exmem_alu_q  <= exmem_alu_d;
      exmem_b_q    <= idex_b_q;
      exmem_tgt_q  <= exmem_tgt_d;
      exmem_cond_q <= exmem_cond_d;
      memwb_ctl_q  <= exmem_ctl_q;
      memwb_alu_q  <= exmem_alu_q;
    end
  end

  // ---------------- assertions ----------------
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!dmem_we && !dmem_re && pc_q == RESET_PC));

  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !exmem_cond_q) |=> (pc_q == $past(pc_q) + WORD_BYTES));

  a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && exmem_cond_q) |=> (pc_q == $past(exmem_tgt_q)));

  a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));
endmodule

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
  localparam int CYC   = 600;
  localparam int STEPS = 800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] irom    [256];
  logic [31:0] dram    [64];
  logic [31:0] ref_mem [64];
  logic [31:0] rr      [32];
  logic [31:0] pcq[$], st_a[$], st_d[$], ld_a[$];
  int checks = 0;
  int errors = 0;
  int np = 0;

  always #2 clk = ~clk;

  pipe5_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  always @(posedge clk) begin
    imem_rdata <= irom[imem_addr[9:2]];
    if (dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;
    dmem_rdata <= dram[dmem_addr[7:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_rr(int fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] f_i(int opc, int rt, int rs, int imm);
    return {6'(opc), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic put(input logic [31:0] w); irom[np] = w; np++; endtask
  task automatic op(input logic [31:0] w); put(w); put(0); put(0); endtask

  function automatic logic [31:0] ref_alu(logic [2:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd6: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  task automatic wr(input logic [4:0] r, input logic [31:0] v);
    if (r != 0) rr[r] = v;
  endtask

  task automatic run_ref();
    logic [31:0] pc, npc, w, a, b, imm, ea, tgt;
    int pend;
    bit take;
    for (int i = 0; i < 32; i++) rr[i] = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = 0;
    pc = 0; pend = 0; tgt = 0;
    for (int s = 0; s < STEPS; s++) begin
      pcq.push_back(pc);
      w = irom[pc[9:2]];
      a = rr[w[25:21]]; b = rr[w[20:16]];
      imm = {{16{w[15]}}, w[15:0]};
      ea = a + imm;
      take = 0; npc = pc + 4;
      case (w[31:26])
        6'h00: if (w[10:3] == 0) wr(w[15:11], ref_alu(w[2:0], a, b));
        6'h23: begin ld_a.push_back(ea); wr(w[20:16], ref_mem[ea[7:2]]); end
        6'h2B: begin st_a.push_back(ea); st_d.push_back(b); ref_mem[ea[7:2]] = b; end
        6'h04: take = (a == 0);
        6'h05: take = (a != 0);
        default: if (w[31:29] == 3'b001) wr(w[20:16], ref_alu(w[28:26], a, imm));
      endcase
      if (pend > 0) begin pend--; if (pend == 0) npc = tgt; end
      if (take) begin pend = 3; tgt = pc + 4 + imm; end
      pc = npc;
    end
  endtask

  task automatic build();
    int bpos, tpos, lpos;
    for (int i = 0; i < 256; i++) irom[i] = 0;
    for (int i = 0; i < 64; i++) dram[i] = 0;
    op(f_i(8, 1, 0, 5));            // r1 = 5
    op(f_i(8, 2, 0, -3));           // r2 = -3
    op(f_rr(0, 3, 1, 2));           // add
    op(f_rr(1, 4, 1, 2));           // sub
    op(f_rr(2, 5, 1, 2));
    op(f_rr(3, 6, 1, 2));
    op(f_rr(4, 7, 1, 2));
    op(f_rr(5, 8, 1, 2));           // 5 < -3 -> 0
    op(f_rr(5, 9, 2, 1));           // -3 < 5 -> 1
    op(f_rr(6, 10, 1, 1));          // 5 << 5
    op(f_rr(7, 11, 2, 1));          // logical shift right
    op(f_i(8'h0B, 12, 0, 16'h8000)); // or-immediate, sign-extended
    op(f_i(8'h0D, 13, 2, 0));       // set-less-than immediate
    op(f_i(8, 0, 0, 9));            // write to r0 discarded
    op(f_i(8'h2B, 1, 0, 64));       // store r1 at 64
    op(f_i(8'h23, 14, 0, 64));      // load back into r14
    op({6'h3F, 5'd0, 5'd22, 16'd77}); // unlisted opcode
    op({6'h00, 5'd1, 5'd1, 5'd23, 5'd1, 6'd0}); // nonzero pad bits: no-op
    op(f_i(8, 16, 0, 0));
    put(f_i(5, 0, 16, 400)); put(0); put(0); put(0);  // not taken
    op(f_i(8, 17, 0, 1));
    bpos = np;
    put(0);                          // patched branch
    put(f_i(8, 18, 0, 11));          // first follower executes
    put(0); put(0);
    put(f_i(8, 19, 0, 22));          // skipped
    put(0); put(0);
    tpos = np;
    irom[bpos] = f_i(4, 0, 16, (tpos - bpos - 1) * 4);
    op(f_i(8, 20, 0, 3));
    lpos = np;
    put(f_i(8, 21, 21, 2)); put(0); put(0);
    put(f_i(8, 20, 20, -1)); put(0); put(0);
    put(f_i(5, 0, 20, (lpos - np - 1) * 4)); put(0); put(0); put(0);
    for (int i = 0; i < 24; i++) put(f_i(8'h2B, i, 0, 128 + 4 * i));
    put(f_i(4, 0, 0, -4));           // halt loop
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ea, ed;
    rst_n = 1'b0;
    build();
    run_ref();
    repeat (3) @(negedge clk);
    chk(imem_addr == 0, "R1 fetch address in reset", imem_addr, 0);
    chk(!dmem_we && !dmem_re, "R1 no data access in reset", {dmem_we, dmem_re}, 0);
    rst_n = 1'b1;
    #0;
    chk(imem_addr == 0, "R1 first fetch address", imem_addr, 0);
    for (int c = 1; c <= CYC; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1) chk(!dmem_we && !dmem_re, "R1 idle first cycle", {dmem_we, dmem_re}, 0);
      chk(imem_addr == pcq[c], "R2 R7 fetch address", imem_addr, pcq[c]);
      chk(!(dmem_we && dmem_re), "R6 single strobe", {dmem_we, dmem_re}, 0);
      if (dmem_we) begin
        if (st_a.size() == 0) chk(0, "R6 R10 unexpected store", dmem_addr, 32'hFFFFFFFF);
        else begin
          ea = st_a.pop_front(); ed = st_d.pop_front();
          chk(dmem_addr == ea, "R6 store address", dmem_addr, ea);
          chk(dmem_wdata == ed, "R6 store data", dmem_wdata, ed);
        end
      end
      if (dmem_re) begin
        if (ld_a.size() == 0) chk(0, "R6 R10 unexpected load", dmem_addr, 32'hFFFFFFFF);
        else begin
          ea = ld_a.pop_front();
          chk(dmem_addr == ea, "R6 load address", dmem_addr, ea);
        end
      end
    end
    chk(st_a.size() == 0, "R6 all stores issued", st_a.size(), 0);
    for (int i = 0; i < 64; i++)
      chk(dram[i] == ref_mem[i], "R3 R4 R5 R6 final memory image", dram[i], ref_mem[i]);
    chk(dram[32+3]  == 32'd2,          "R4 R9 add after two gaps", dram[32+3], 2);
    chk(dram[32+4]  == 32'd8,          "R4 sub", dram[32+4], 8);
    chk(dram[32+8]  == 32'd0,          "R4 signed slt false", dram[32+8], 0);
    chk(dram[32+10] == 32'd160,        "R4 shift left", dram[32+10], 160);
    chk(dram[32+11] == 32'h07FFFFFF,   "R4 logical shift right", dram[32+11], 32'h07FFFFFF);
    chk(dram[32+12] == 32'hFFFF8000,   "R3 R5 sign-extended immediate", dram[32+12], 32'hFFFF8000);
    chk(dram[32+13] == 32'd1,          "R5 slti", dram[32+13], 1);
    chk(dram[32+14] == 32'd5,          "R6 load result", dram[32+14], 5);
    chk(dram[32+0]  == 32'd0,          "R8 register 0 stays zero", dram[32+0], 0);
    chk(dram[32+17] == 32'd1,          "R7 fall-through when not taken", dram[32+17], 1);
    chk(dram[32+18] == 32'd11,         "R7 follower executes", dram[32+18], 11);
    chk(dram[32+19] == 32'd0,          "R7 skipped word", dram[32+19], 0);
    chk(dram[32+21] == 32'd6,          "R7 backward loop count", dram[32+21], 6);
    chk(dram[32+22] == 32'd0,          "R10 unlisted opcode", dram[32+22], 0);
    chk(dram[32+23] == 32'd0,          "R10 bad pad bits", dram[32+23], 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule